// File: doc/BRIEF.md
# Compact Branch Decode and Resolve Unit

This unit examines one 32-bit instruction word together with its PC and the two source operand values that the register file has already read for it. It works out whether the word is a branch or jump with no delay slot. If it is, the unit reports which variant it is, whether the branch is taken, where it goes, and whether the return register must receive PC+4. Some major opcodes carry several branch types. The unit tells these apart by comparing the two source register numbers: each may be zero, the two may be equal, or they may be ordered.

The unit also raises a reserved-instruction exception in two cases: an encoding that is illegal, and any branch or jump placed in the slot right after an accepted compact branch. It keeps a single-bit flag from one accepted instruction to the next to track that slot. Words that are not compact branches, including the older delay-slot branches, pass through with `cb_is_compact` low and no exception. An outer decoder handles them.

An instruction is accepted on each clock edge where `in_valid` is high. All results appear on registered outputs one cycle later.

Top module: `cbr_resolve`

## Requirements
- R1: While `rst_n` is low, and after it, until the first accepted word, every output is zero and the forbidden-slot flag is clear.
- R2: `cb_kind` is {group[2:0], form[1:0]}. The groups are: op 0x06 → 0, 0x07 → 1, 0x16 → 2, 0x17 → 3, 0x08 → 4, 0x18 → 5, 0x32/0x3A → 6, 0x36/0x3E → 7. For every word that is not compact, `cb_kind` is 0 and `cb_is_compact`, `cb_taken`, `cb_link` and `cb_target` are all 0. Op 0x06/0x07 with rt==0 is a legacy branch: it is not compact and raises no exception.
- R3: For op 0x06/0x07 with rt!=0, the form is chosen by register numbers. rs==0 gives form 1, a linking branch on GPR[rt]<=0 (0x06) or >0 (0x07). rs==rt gives form 2, a linking branch on GPR[rt]>=0 (0x06) or <0 (0x07). Any other pair gives form 3, a non-linking branch on unsigned GPR[rs]>=GPR[rt] (0x06) or < (0x07).
- R4: Op 0x16/0x17 selects forms 1 to 3 with the same conditions as R3, but none of them link, and form 3 compares signed. For these opcodes rt==0 raises `cb_rsvd_exc`.
- R5: For op 0x08, rs>=rt (register numbers) gives form 2, which branches on signed 32-bit add overflow. Overflow means the sum's sign differs from the signs of both operands. rs==0<rt gives form 1, a linking branch on GPR[rt]==0. Anything else gives form 3, a branch on GPR[rs]==GPR[rt]. Op 0x18 uses the same forms with each condition inverted.
- R6: Op 0x32 (form 0) and op 0x3A (form 1, linking) are always taken. Their offset is the 26-bit field, sign-extended and shifted left by 2.
- R7: For op 0x36/0x3E with rs!=0, form 0 (0x36) branches if GPR[rs]==0 and form 1 (0x3E) branches if GPR[rs]!=0, using a 21-bit offset shifted left by 2. With rs==0, the word is an always-taken jump to GPR[rt] plus the sign-extended, unshifted 16-bit immediate. That is form 2 for 0x36, and form 3 for 0x3E, which also links.
- R8: PC-relative targets are PC+4 plus the shifted offset. The 16-bit offsets of groups 0–5 are shifted left by 2. The target is reported whether or not the branch is taken.
- R9: Every linking form raises `cb_link` whether or not the branch is taken.
- R10: After an accepted compact branch that raised no exception, the next accepted word raises `cb_rsvd_exc` if it is any branch or jump. This covers op 0x01–0x05, op 0x00 with funct 0x08/0x09, and every compact opcode. An exception forces `cb_is_compact`, `cb_kind`, `cb_taken`, `cb_link` and `cb_target` to 0 and clears the flag. The flag changes only on accepted words.
- R11: `out_valid` is high exactly one cycle after an accepted word. The other outputs hold while no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the word on this edge |
| in_insn | input | 32 | Instruction word |
| in_pc | input | XLEN | Address of the word |
| in_rs_val | input | XLEN | Value of the register named by bits 25:21 |
| in_rt_val | input | XLEN | Value of the register named by bits 20:16 |
| out_valid | output | 1 | Results below belong to the last accepted word |
| cb_is_compact | output | 1 | Word is a compact branch or jump |
| cb_kind | output | 5 | Variant code, {group, form} |
| cb_taken | output | 1 | Branch or jump is taken |
| cb_target | output | XLEN | Destination address |
| cb_link | output | 1 | Return register gets PC+4 |
| cb_rsvd_exc | output | 1 | Reserved-instruction exception |

## Verification
The bench builds the unit with the default XLEN of 32. This width makes the overflow forms depend on the full operand width, and it lets random operand values reach the sign boundary, where signed and unsigned compares disagree. Register numbers are drawn from a small set, so rs==0, rs==rt, rs<rt and rs>rt all occur often under every shared opcode. Branch words are mixed densely with non-branch words, so the forbidden slot is entered, reported and cleared many times.

// File: rtl/cbr_resolve.sv
module cbr_resolve #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_rs_val,
  input  logic [XLEN-1:0] in_rt_val,
  output logic            out_valid,
  output logic            cb_is_compact,
  output logic [4:0]      cb_kind,
  output logic            cb_taken,
  output logic [XLEN-1:0] cb_target,
  output logic            cb_link,
  output logic            cb_rsvd_exc
);
  localparam int PAD16 = XLEN - 18;
  localparam int PAD21 = XLEN - 23;
  localparam int PAD26 = XLEN - 28;
  localparam int PADJ  = XLEN - 16;

  logic [5:0] op;
  logic [4:0] rs, rt;
  logic rs0, rt0, req;
  assign op  = in_insn[31:26];
  assign rs  = in_insn[25:21];
  assign rt  = in_insn[20:16];
  assign rs0 = (rs == 5'd0);
  assign rt0 = (rt == 5'd0);
  assign req = (rs == rt);

  logic [XLEN-1:0] pc4, off16, off21, off26, immj;
  assign pc4   = in_pc + XLEN'(4);
  assign off16 = {{PAD16{in_insn[15]}}, in_insn[15:0], 2'b00};
  assign off21 = {{PAD21{in_insn[20]}}, in_insn[20:0], 2'b00};
  assign off26 = {{PAD26{in_insn[25]}}, in_insn[25:0], 2'b00};
  assign immj  = {{PADJ{in_insn[15]}}, in_insn[15:0]};

  logic signed [XLEN-1:0] sa, sb;
  assign sa = in_rs_val;
  assign sb = in_rt_val;

  logic [31:0] sum32;
  logic ovf, b_zero, a_zero;
  assign sum32  = in_rs_val[31:0] + in_rt_val[31:0];
  assign ovf    = (sum32[31] != in_rs_val[31]) && (sum32[31] != in_rt_val[31]);
  assign b_zero = (in_rt_val == '0);
  assign a_zero = (in_rs_val == '0);

  logic            comp, cond, lnk, illegal, isbr;
  logic [2:0]      grp;
  logic [1:0]      form;
  logic [XLEN-1:0] tgt;

  always_comb begin
    comp = 1'b0; cond = 1'b0; lnk = 1'b0; illegal = 1'b0; isbr = 1'b0;
    grp = 3'd0; form = 2'd0; tgt = pc4 + off16;
    case (op)
      6'h06, 6'h07, 6'h16, 6'h17: begin
        isbr = 1'b1;
        if (rt0) begin
          illegal = op[4];
        end else begin
          comp = 1'b1;
          grp  = {1'b0, op[4], op[0]};
          if (rs0) begin
            form = 2'd1;
            cond = op[0] ? (sb > 0) : (sb <= 0);
            lnk  = ~op[4];
          end else if (req) begin
            form = 2'd2;
            cond = op[0] ? (sb < 0) : (sb >= 0);
            lnk  = ~op[4];
          end else begin
            form = 2'd3;
            if (op[4]) cond = op[0] ? (sa < sb) : (sa >= sb);
            else       cond = op[0] ? (in_rs_val < in_rt_val) : (in_rs_val >= in_rt_val);
          end
        end
      end
      6'h08, 6'h18: begin
        isbr = 1'b1;
        comp = 1'b1;
        grp  = op[4] ? 3'd5 : 3'd4;
        if (rs >= rt) begin
          form = 2'd2;
          cond = ovf ^ op[4];
        end else if (rs0) begin
          form = 2'd1;
          cond = b_zero ^ op[4];
          lnk  = 1'b1;
        end else begin
          form = 2'd3;
          cond = (in_rs_val == in_rt_val) ^ op[4];
        end
      end
      6'h32, 6'h3A: begin
        isbr = 1'b1;
        comp = 1'b1;
        grp  = 3'd6;
        form = {1'b0, op[3]};
        cond = 1'b1;
        lnk  = op[3];
        tgt  = pc4 + off26;
      end
      6'h36, 6'h3E: begin
        isbr = 1'b1;
        comp = 1'b1;
        grp  = 3'd7;
        if (!rs0) begin
          form = {1'b0, op[3]};
          cond = a_zero ^ op[3];
          tgt  = pc4 + off21;
        end else begin
          form = {1'b1, op[3]};
          cond = 1'b1;
          lnk  = op[3];
          tgt  = in_rt_val + immj;
        end
      end
      6'h01, 6'h02, 6'h03, 6'h04, 6'h05: isbr = 1'b1;
      6'h00: isbr = (in_insn[5:1] == 5'b00100);
      default: ;
    endcase
  end

  logic fslot, exc, keep;
  assign exc  = illegal | (fslot & isbr);
  assign keep = comp & ~exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fslot         <= 1'b0;
      out_valid     <= 1'b0;
      cb_is_compact <= 1'b0;
      cb_kind       <= '0;
      cb_taken      <= 1'b0;
      cb_target     <= '0;
      cb_link       <= 1'b0;
      cb_rsvd_exc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fslot         <= keep;
        cb_is_compact <= keep;
        cb_kind       <= keep ? {grp, form} : 5'd0;
        cb_taken      <= keep & cond;
        cb_target     <= keep ? tgt : '0;
        cb_link       <= keep & lnk;
        cb_rsvd_exc   <= exc;
      end
    end
  end
endmodule

// File: rtl/cbr_resolve_chk.sv
module cbr_resolve_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            cb_is_compact,
  input logic [4:0]      cb_kind,
  input logic            cb_taken,
  input logic [XLEN-1:0] cb_target,
  input logic            cb_link,
  input logic            cb_rsvd_exc
);
  assert_exc_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cb_rsvd_exc |-> !cb_is_compact && !cb_taken && !cb_link && cb_kind == 5'd0);

  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_valid && cb_is_compact) |=> !cb_is_compact);

  assert_link_needs_compact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cb_link |-> cb_is_compact);

  assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_is_compact && cb_kind[4:2] == 3'd6) |-> cb_taken);

  assert_kind_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cb_is_compact |-> cb_kind == 5'd0 && cb_target == '0);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(cb_kind) && $stable(cb_rsvd_exc));
endmodule

bind cbr_resolve cbr_resolve_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .cb_is_compact(cb_is_compact), .cb_kind(cb_kind), .cb_taken(cb_taken),
  .cb_target(cb_target), .cb_link(cb_link), .cb_rsvd_exc(cb_rsvd_exc)
);

// File: tb/sim_cbr_resolve.sv
module sim_cbr_resolve;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] in_insn = 0, in_pc = 0, in_rs_val = 0, in_rt_val = 0;
  logic        out_valid, cb_is_compact, cb_taken, cb_link, cb_rsvd_exc;
  logic [4:0]  cb_kind;
  logic [31:0] cb_target;

  cbr_resolve #(.XLEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_pc(in_pc), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .out_valid(out_valid), .cb_is_compact(cb_is_compact), .cb_kind(cb_kind),
    .cb_taken(cb_taken), .cb_target(cb_target), .cb_link(cb_link),
    .cb_rsvd_exc(cb_rsvd_exc)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic m_flag = 0;
  logic pend = 0, pend_v = 0;
  logic [40:0] pend_exp;
  string pend_tag;

  // {exc, comp, kind[4:0], taken, link, target[31:0]}
  function automatic logic [40:0] model(input logic [31:0] w, pcv, a, b, input logic fs);
    logic [5:0] op = w[31:26];
    logic [4:0] rs = w[25:21], rt = w[20:16];
    logic [31:0] p4 = pcv + 4;
    logic [31:0] s16 = {{14{w[15]}}, w[15:0], 2'b00};
    logic br = 0, comp = 0, tk = 0, lk = 0, bad = 0;
    logic [4:0] kd = 0;
    logic [31:0] tg = 0, sm;
    if (op == 6'h01 || op == 6'h02 || op == 6'h03 || op == 6'h04 || op == 6'h05) br = 1;
    if (op == 6'h00 && (w[5:0] == 6'h08 || w[5:0] == 6'h09)) br = 1;
    if (op == 6'h06 || op == 6'h07 || op == 6'h16 || op == 6'h17) begin
      br = 1;
      if (rt == 0) bad = (op == 6'h16 || op == 6'h17);
      else begin
        comp = 1; tg = p4 + s16;
        kd[4:2] = (op == 6'h06) ? 0 : (op == 6'h07) ? 1 : (op == 6'h16) ? 2 : 3;
        if (rs == 0) begin
          kd[1:0] = 1; lk = (op == 6'h06 || op == 6'h07);
          tk = (op[0]) ? ($signed(b) > 0) : ($signed(b) <= 0);
        end else if (rs == rt) begin
          kd[1:0] = 2; lk = (op == 6'h06 || op == 6'h07);
          tk = (op[0]) ? ($signed(b) < 0) : ($signed(b) >= 0);
        end else begin
          kd[1:0] = 3;
          case (op)
            6'h06: tk = a >= b;
            6'h07: tk = a < b;
            6'h16: tk = $signed(a) >= $signed(b);
            default: tk = $signed(a) < $signed(b);
          endcase
        end
      end
    end
    if (op == 6'h08 || op == 6'h18) begin
      br = 1; comp = 1; tg = p4 + s16; kd[4:2] = (op == 6'h08) ? 4 : 5;
      if (rs >= rt) begin
        sm = a + b; kd[1:0] = 2;
        tk = (a[31] == b[31]) && (sm[31] != a[31]);
      end else if (rs == 0) begin
        kd[1:0] = 1; lk = 1; tk = (b == 0);
      end else begin
        kd[1:0] = 3; tk = (a == b);
      end
      if (op == 6'h18) tk = !tk;
    end
    if (op == 6'h32 || op == 6'h3A) begin
      br = 1; comp = 1; tk = 1; lk = (op == 6'h3A);
      kd = (op == 6'h3A) ? 5'd25 : 5'd24;
      tg = p4 + {{4{w[25]}}, w[25:0], 2'b00};
    end
    if (op == 6'h36 || op == 6'h3E) begin
      br = 1; comp = 1;
      if (rs != 0) begin
        kd = (op == 6'h36) ? 5'd28 : 5'd29;
        tk = (op == 6'h36) ? (a == 0) : (a != 0);
        tg = p4 + {{9{w[20]}}, w[20:0], 2'b00};
      end else begin
        kd = (op == 6'h36) ? 5'd30 : 5'd31;
        tk = 1; lk = (op == 6'h3E);
        tg = b + {{16{w[15]}}, w[15:0]};
      end
    end
    if (bad || (fs && br)) return {1'b1, 40'd0};
    if (!comp) return 41'd0;
    return {1'b0, 1'b1, kd, tk, lk, tg};
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'h06, 6'h07: return "R3";
      6'h16, 6'h17: return "R4";
      6'h08, 6'h18: return "R5";
      6'h32, 6'h3A: return "R6";
      6'h36, 6'h3E: return "R7";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (!pend) return;
    chk("R11", "out_valid", {31'd0, out_valid}, {31'd0, pend_v});
    if (pend_v) begin
      chk(pend_exp[40] ? "R10" : pend_tag, "exception", {31'd0, cb_rsvd_exc}, {31'd0, pend_exp[40]});
      chk(pend_tag, "is_compact", {31'd0, cb_is_compact}, {31'd0, pend_exp[39]});
      chk(pend_tag, "kind", {27'd0, cb_kind}, {27'd0, pend_exp[38:34]});
      chk(pend_tag, "taken", {31'd0, cb_taken}, {31'd0, pend_exp[33]});
      chk("R9", "link", {31'd0, cb_link}, {31'd0, pend_exp[32]});
      chk("R8", "target", cb_target, pend_exp[31:0]);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, pcv, a, b);
    @(negedge clk);
    compare_pending();
    in_valid = v; in_insn = w; in_pc = pcv; in_rs_val = a; in_rt_val = b;
    pend = 1; pend_v = v; pend_tag = tag_of(w[31:26]);
    if (v) begin
      pend_exp = model(w, pcv, a, b, m_flag);
      m_flag = pend_exp[39] & ~pend_exp[40];
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam logic [31:0] NOP = 32'h0000_0000;

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] ops [14] = '{6'h06, 6'h07, 6'h16, 6'h17, 6'h08, 6'h18, 6'h32,
                             6'h3A, 6'h36, 6'h3E, 6'h04, 6'h00, 6'h23, 6'h0D};
    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h10};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", {31'd0, out_valid}, 0);
    chk("R1", "is_compact", {31'd0, cb_is_compact}, 0);
    chk("R1", "target", cb_target, 0);
    chk("R1", "exception", {31'd0, cb_rsvd_exc}, 0);
    rst_n = 1;

    // R5: overflow taken on 0x08, not on 0x18
    step(1, mk(6'h08, 5'd5, 5'd3, 16'h0004), 32'h1000, 32'h7FFF_FFFF, 32'h1);
    step(1, NOP, 32'h1004, 0, 0);
    step(1, mk(6'h18, 5'd5, 5'd3, 16'h0004), 32'h1008, 32'h7FFF_FFFF, 32'h1);
    step(1, NOP, 32'h100C, 0, 0);
    // R6: backward unconditional branch, then R10 forbidden legacy branch
    step(1, {6'h32, 26'h3FF_FFFF}, 32'h2000, 0, 0);
    step(1, mk(6'h04, 5'd1, 5'd2, 16'h0010), 32'h2004, 0, 0);
    step(1, {6'h3A, 26'h000_0010}, 32'h2008, 0, 0);
    step(0, NOP, 0, 0, 0);
    step(1, mk(6'h00, 5'd31, 5'd0, 16'h0009), 32'h200C, 0, 0);
    step(1, NOP, 32'h2010, 0, 0);
    // R7: indirect jump with link and negative immediate
    step(1, mk(6'h3E, 5'd0, 5'd9, 16'hFFF0), 32'h3000, 0, 32'h4000_0100);
    step(1, NOP, 32'h3004, 0, 0);
    // R4: rt==0 reserved
    step(1, mk(6'h16, 5'd4, 5'd0, 16'h0001), 32'h3008, 0, 0);
    // R2: legacy form passes through
    step(1, mk(6'h07, 5'd4, 5'd0, 16'h0001), 32'h300C, 0, 0);
    // R3: unsigned vs sign boundary
    step(1, mk(6'h06, 5'd2, 5'd7, 16'h8000), 32'h3010, 32'h8000_0000, 32'h1);
    step(1, NOP, 32'h3014, 0, 0);
    step(1, mk(6'h16, 5'd2, 5'd7, 16'h8000), 32'h3018, 32'h8000_0000, 32'h1);

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op = ops[$urandom_range(0, 13)];
      logic [4:0] rs = 5'($urandom_range(0, 3));
      logic [4:0] rt = 5'($urandom_range(0, 3));
      logic [31:0] w = {op, rs, rt, 16'($urandom)};
      logic [31:0] a = ($urandom_range(0, 1) != 0) ? vals[$urandom_range(0, 7)] : $urandom;
      logic [31:0] b = ($urandom_range(0, 1) != 0) ? vals[$urandom_range(0, 7)] : $urandom;
      if ($urandom_range(0, 3) == 0) w[25:0] = 26'($urandom);
      if (op == 6'h00) w[5:0] = 6'($urandom_range(7, 10));
      step($urandom_range(0, 7) != 0, w, {$urandom, 2'b00}, a, b);
    end
    step(0, NOP, 0, 0, 0);
    @(negedge clk);
    compare_pending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule